// File: doc/BRIEF.md
# Weighted Round-Robin Bus Arbiter

This block shares one bus among four requestors: three external bus masters (indices 0, 1 and 2) and a host CPU port (index 3). Turns pass in a fixed circular order, and each grant is a registered one-cycle pulse that stands for one bus transaction. A requestor can be given extra weight through a pair of 4-bit fields. The repeat field lets it keep the bus for several turns in a row. The hold field forces the bus to stay idle for a set number of clocks after each of its transactions before the next decision is made.

Weighting is qualified per requestor by an enable bit, and it applies only when both fields are nonzero. Each requestor also has an override bit. While that requestor is asking for the bus, the override switches off the weighting of every other requestor. The circular order stays the same. The external masters present active-low requests and the CPU presents an active-high request. The bus-idle input says whether the bus was quiet on a given clock, and only those clocks count down a hold interval.

Top module: `wrr_bus_arbiter`

## Requirements
- R1: After an asynchronous active-low reset, all grant outputs are 0. The rotation pointer points at the CPU (index 3), so the first grant goes to the lowest-numbered requestor that is asking, starting from index 0.
- R2: Requestor i asks when bit i of the request vector is 1. That vector is {req_cpu, ~req_ext_n}: the CPU is active high at index 3 and the masters are active low at indices 0..2. Without weighting, grants go one per clock, back to back, in the circular order 0,1,2,3. Each grant appears on the clock after the request is sampled.
- R3: While no requestor asks, no grant is issued and the pointer is kept. The next grant goes to the first asking requestor after the one granted last.
- R4: A weighted requestor whose repeat field is R receives up to R consecutive turns, including the turn that started it. After that the turn passes on. A later return to the same requestor starts a fresh count.
- R5: After each grant to a weighted requestor whose hold field is H, no grant is issued until H clock edges with bus_idle high have passed. Edges with bus_idle low do not count. The next decision comes on the edge after the H-th counted edge.
- R6: A requestor is weighted only when its enable bit is 1 and both its repeat field and its hold field are nonzero. In any other case its fields have no effect and it gets single plain turns.
- R7: While requestor j has its override bit set and is asking, every other requestor is treated as unweighted. A hold interval that is running for another requestor ends at once. The circular order is unchanged, and requestor j's own weighting is not affected.
- R8: The grant outputs are registered, and at most one of them is 1 in any cycle. A grant is only ever given to a requestor that was asking at the sampling edge.
- R9: The configuration fields are packed per requestor. Requestor i takes cfg_repeat[4i+3:4i], cfg_hold[4i+3:4i] and bit i of cfg_enable and of cfg_override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_cpu | input | 1 | CPU request, active high (index 3) |
| req_ext_n | input | 3 | External master requests, active low (indices 0..2) |
| bus_idle | input | 1 | High on clocks where the bus carries no transaction |
| cfg_repeat | input | 16 | Repeat field per requestor, 4 bits each |
| cfg_hold | input | 16 | Hold field per requestor, 4 bits each |
| cfg_enable | input | 4 | Weighting enable per requestor |
| cfg_override | input | 4 | Override bit per requestor |
| grant | output | 4 | One-hot grant pulses, bit i for requestor i |

## Verification
The risky overlap is a running hold interval for one master in the same cycle as a request from another master whose override bit is set. The hold countdown and the override cancellation then compete for the same decision edge. The bench sets up this case with a weighted master 0 that has just been granted. It then asserts the override holder's request one clock later and expects that holder to be granted on the very next edge, with no idle gap and with master 0's remaining repeat credit dropped. It also checks the same rotation with the override present from the start, to confirm that the order is unchanged.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
   localparam int unsigned WRR_MAX_REQ = 16;
   localparam int unsigned WRR_MAX_CNT_W = 8;
endpackage

// File: rtl/wrr_qualify.sv
module wrr_qualify #(
   parameter int NUM_REQ     = 4,
   parameter int CNT_W       = 4,
   parameter bit OVERRIDE_EN = 1'b1
) (
   input  logic [NUM_REQ-1:0]       req,
   input  logic [NUM_REQ*CNT_W-1:0] cfg_repeat,
   input  logic [NUM_REQ*CNT_W-1:0] cfg_hold,
   input  logic [NUM_REQ-1:0]       cfg_enable,
   input  logic [NUM_REQ-1:0]       cfg_override,
   output logic [NUM_REQ-1:0]       weighted,
   output logic [NUM_REQ-1:0]       suppressed
);
   logic [NUM_REQ-1:0] claim;

   generate
      if (OVERRIDE_EN) begin : g_ovr
         assign claim = cfg_override & req;
         for (genvar i = 0; i < NUM_REQ; i++) begin : g_sup
            localparam logic [NUM_REQ-1:0] SELF = NUM_REQ'(1) << i;
            assign suppressed[i] = |(claim & ~SELF);
         end
      end else begin : g_no_ovr
         assign claim      = '0;
         assign suppressed = '0;
      end
   endgenerate

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_w
      assign weighted[i] = cfg_enable[i]
                           & (cfg_repeat[i*CNT_W +: CNT_W] != '0)
                           & (cfg_hold[i*CNT_W +: CNT_W] != '0)
                           & ~suppressed[i];
   end
endmodule

// File: rtl/wrr_rr_pick.sv
module wrr_rr_pick #(
   parameter int NUM_REQ = 4,
   parameter int IDX_W   = $clog2(NUM_REQ)
) (
   input  logic [NUM_REQ-1:0] req,
   input  logic [IDX_W-1:0]   last,
   output logic               vld,
   output logic [IDX_W-1:0]   win
);
   always_comb begin
      int              idx;
      logic [IDX_W-1:0] cand;
      idx  = 0;
      cand = '0;
      vld  = 1'b0;
      win  = last;
      // farthest first, so the nearest requester after 'last' overwrites
      for (int k = NUM_REQ; k >= 1; k--) begin
         idx  = (int'(last) + k) % NUM_REQ;
         cand = IDX_W'(idx);
         if (req[cand]) begin
            vld = 1'b1;
            win = cand;
         end
      end
   end
endmodule

// File: rtl/wrr_bus_arbiter.sv
module wrr_bus_arbiter #(
   parameter int NUM_REQ     = 4,
   parameter int CNT_W       = 4,
   parameter bit OVERRIDE_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_cpu,
   input  logic [NUM_REQ-2:0]       req_ext_n,
   input  logic                     bus_idle,
   input  logic [NUM_REQ*CNT_W-1:0] cfg_repeat,
   input  logic [NUM_REQ*CNT_W-1:0] cfg_hold,
   input  logic [NUM_REQ-1:0]       cfg_enable,
   input  logic [NUM_REQ-1:0]       cfg_override,
   output logic [NUM_REQ-1:0]       grant
);
   import wrr_pkg::*;

   localparam int IDX_W = $clog2(NUM_REQ);
   localparam logic [IDX_W-1:0] CPU_IDX = IDX_W'(NUM_REQ - 1);

   generate
      if (NUM_REQ < 2 || NUM_REQ > WRR_MAX_REQ) begin : g_bad_num
         $error("wrr_bus_arbiter: NUM_REQ out of range");
      end
      if (CNT_W < 1 || CNT_W > WRR_MAX_CNT_W) begin : g_bad_cnt
         $error("wrr_bus_arbiter: CNT_W out of range");
      end
   endgenerate

   logic [NUM_REQ-1:0] req;
   logic [NUM_REQ-1:0] weighted;
   logic [NUM_REQ-1:0] suppressed;
   logic [CNT_W-1:0]   rep_a  [NUM_REQ];
   logic [CNT_W-1:0]   hold_a [NUM_REQ];

   logic [NUM_REQ-1:0] gnt_q, gnt_d;
   logic [IDX_W-1:0]   last_q, last_d;
   logic [CNT_W-1:0]   credit_q, credit_d;
   logic [CNT_W-1:0]   hold_q, hold_d;

   logic               pick_vld;
   logic [IDX_W-1:0]   pick_idx;
   logic               hold_run;
   logic               again;

   assign req = {req_cpu, ~req_ext_n};

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_fields
      assign rep_a[g]  = cfg_repeat[g*CNT_W +: CNT_W];
      assign hold_a[g] = cfg_hold[g*CNT_W +: CNT_W];
   end

   wrr_qualify #(
      .NUM_REQ(NUM_REQ), .CNT_W(CNT_W), .OVERRIDE_EN(OVERRIDE_EN)
   ) u_qual (
      .req(req), .cfg_repeat(cfg_repeat), .cfg_hold(cfg_hold),
      .cfg_enable(cfg_enable), .cfg_override(cfg_override),
      .weighted(weighted), .suppressed(suppressed)
   );

   wrr_rr_pick #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_pick (
      .req(req), .last(last_q), .vld(pick_vld), .win(pick_idx)
   );

   // a running hold is dropped as soon as another requestor overrides it
   assign hold_run = (hold_q != '0) && !suppressed[last_q];
   assign again    = (credit_q != '0) && weighted[last_q] && req[last_q];

   always_comb begin
      gnt_d    = '0;
      last_d   = last_q;
      credit_d = credit_q;
      hold_d   = hold_q;
      if (hold_run) begin
         if (bus_idle) hold_d = hold_q - 1'b1;
      end else begin
         hold_d = '0;
         if (again) begin
            gnt_d[last_q] = 1'b1;
            credit_d      = credit_q - 1'b1;
            hold_d        = hold_a[last_q];
         end else if (pick_vld) begin
            gnt_d[pick_idx] = 1'b1;
            last_d          = pick_idx;
            credit_d        = weighted[pick_idx] ? rep_a[pick_idx] - 1'b1 : '0;
            hold_d          = weighted[pick_idx] ? hold_a[pick_idx] : '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt_q    <= '0;
         last_q   <= CPU_IDX;
         credit_q <= '0;
         hold_q   <= '0;
      end else begin
         gnt_q    <= gnt_d;
         last_q   <= last_d;
         credit_q <= credit_d;
         hold_q   <= hold_d;
      end
   end

   assign grant = gnt_q;

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R8

   AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (|gnt_d) |=> |(grant & $past(req))); // R8

   AST_IDLE_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (grant == '0)); // R3

   AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_run |=> (grant == '0)); // R5

   AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_run && !bus_idle) |=> (hold_q == $past(hold_q))); // R5

   AST_PTR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (grant == '0) |-> (last_q == $past(last_q)) || $past(!rst_n)); // R3
endmodule

// File: tb/sim_wrr_bus_arbiter.sv
module sim_wrr_bus_arbiter;
   localparam time CLK_P = 10ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_cpu;
   logic [2:0]  req_ext_n;
   logic        bus_idle;
   logic [15:0] cfg_repeat, cfg_hold;
   logic [3:0]  cfg_enable, cfg_override;
   logic [3:0]  grant;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   wrr_bus_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .req_cpu(req_cpu), .req_ext_n(req_ext_n),
      .bus_idle(bus_idle), .cfg_repeat(cfg_repeat), .cfg_hold(cfg_hold),
      .cfg_enable(cfg_enable), .cfg_override(cfg_override), .grant(grant)
   );

   // bit i of v is requestor i; index 3 is the CPU
   task automatic set_req(input logic [3:0] v);
      req_cpu   = v[3];
      req_ext_n = ~v[2:0];
   endtask

   task automatic chk(input logic [3:0] exp, input string tag);
      @(negedge clk);
      n_cmp++;
      if (grant !== exp) begin
         n_bad++;
         $display("FAIL %s: grant=%b expected=%b at %0t", tag, grant, exp, $time);
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      set_req(4'b0000);
      bus_idle = 1'b1;
      cfg_repeat = '0; cfg_hold = '0; cfg_enable = '0; cfg_override = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      apply_reset();
      chk(4'b0000, "R1 reset idle");
      set_req(4'b1111);
      chk(4'b0001, "R1 first grant to index 0");
   endtask

   task automatic t_plain();
      apply_reset();
      set_req(4'b1111);
      chk(4'b0001, "R2 rotate 0");
      chk(4'b0010, "R2 rotate 1");
      chk(4'b0100, "R2 rotate 2");
      chk(4'b1000, "R2 rotate cpu");
      chk(4'b0001, "R2 wrap to 0");
   endtask

   task automatic t_idle_ptr();
      apply_reset();
      set_req(4'b0010);
      chk(4'b0010, "R2 single master 1");
      set_req(4'b0000);
      chk(4'b0000, "R3 no request no grant");
      chk(4'b0000, "R3 still idle");
      set_req(4'b1111);
      chk(4'b0100, "R3 resume after last granted");
   endtask

   task automatic t_repeat_hold();
      apply_reset();
      cfg_enable = 4'b0001;
      cfg_repeat[3:0] = 4'd3;
      cfg_hold[3:0]   = 4'd1;
      set_req(4'b1111);
      chk(4'b0001, "R4 turn 1");
      chk(4'b0000, "R5 gap 1");
      chk(4'b0001, "R4 turn 2");
      chk(4'b0000, "R5 gap 2");
      chk(4'b0001, "R4 turn 3");
      chk(4'b0000, "R5 gap 3");
      chk(4'b0010, "R4 rotate after credit");
      chk(4'b0100, "R4 master 2");
      chk(4'b1000, "R4 cpu");
      chk(4'b0001, "R4 fresh turn for 0");
   endtask

   task automatic t_hold_idle();
      apply_reset();
      cfg_enable = 4'b1000;
      cfg_repeat[15:12] = 4'd1;
      cfg_hold[15:12]   = 4'd2;
      bus_idle = 1'b0;
      set_req(4'b1000);
      chk(4'b1000, "R9 cpu grant");
      chk(4'b0000, "R5 busy 1");
      chk(4'b0000, "R5 busy 2");
      chk(4'b0000, "R5 busy 3");
      bus_idle = 1'b1;
      chk(4'b0000, "R5 idle count 1");
      chk(4'b0000, "R5 idle count 2");
      chk(4'b1000, "R5 cpu after hold");
   endtask

   task automatic t_enable_pair();
      apply_reset();
      cfg_repeat[3:0] = 4'd3;
      cfg_hold[3:0]   = 4'd3;
      set_req(4'b1111);
      chk(4'b0001, "R6 enable off 0");
      chk(4'b0010, "R6 enable off 1");
      apply_reset();
      cfg_enable = 4'b0001;
      cfg_repeat[3:0] = 4'd3;
      set_req(4'b1111);
      chk(4'b0001, "R6 hold zero 0");
      chk(4'b0010, "R6 hold zero 1");
      apply_reset();
      cfg_enable = 4'b0001;
      cfg_hold[3:0] = 4'd3;
      set_req(4'b1111);
      chk(4'b0001, "R6 repeat zero 0");
      chk(4'b0010, "R6 repeat zero 1");
   endtask

   task automatic t_override();
      apply_reset();
      cfg_enable = 4'b0001;
      cfg_repeat[3:0] = 4'd3;
      cfg_hold[3:0]   = 4'd2;
      cfg_override = 4'b0100;
      set_req(4'b0101);
      chk(4'b0001, "R7 order 0");
      chk(4'b0100, "R7 order 2 no gap");
      chk(4'b0001, "R7 order 0 again");
      chk(4'b0100, "R7 order 2 again");
      apply_reset();
      cfg_enable = 4'b0001;
      cfg_repeat[3:0] = 4'd3;
      cfg_hold[3:0]   = 4'd2;
      cfg_override = 4'b0100;
      set_req(4'b0001);
      chk(4'b0001, "R7 weighted grant 0");
      set_req(4'b0101);
      chk(4'b0100, "R7 hold cancelled by override");
      apply_reset();
      cfg_enable = 4'b0001;
      cfg_repeat[3:0] = 4'd2;
      cfg_hold[3:0]   = 4'd1;
      cfg_override = 4'b0001;
      set_req(4'b0011);
      chk(4'b0001, "R7 own override keeps weight");
      chk(4'b0000, "R7 own hold gap");
      chk(4'b0001, "R7 own repeat");
   endtask

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: expired, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_plain();
      t_idle_ptr();
      t_repeat_hold();
      t_hold_idle();
      t_enable_pair();
      t_override();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule